// File: doc/BRIEF.md
# Paired-Register Double-Word Load/Store Sequencer

This block carries out a 64-bit load or store on a 32-bit single-word memory port by splitting it into two word accesses on an even/odd register pair. A request names a base value, a signed 16-bit displacement, an even register index `rt` and a direction. The block adds the sign-extended displacement to the base and clears the two low bits of the sum. It then runs two word accesses in a fixed order, steering data between `rt`, `rt+1` and memory.

A load puts the word at the aligned address into `rt+1` and the word at address+4 into `rt`. A store first writes `rt` to address+4, then writes `rt+1` to the aligned address. Both register operands of a store are sampled through two read ports in the cycle the request is accepted. Loaded words reach the register file only as each read access completes. The `done` pulse marks the point after which both loaded words may be used, so a consumer issued right behind the load must wait for it.

The request side is valid/ready: a request transfers on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the block is idle. The memory side is also valid/ready: `mem_req` with its address, direction and write data stays asserted and unchanged until the memory returns `mem_ready`, so the memory may stall each access for any number of cycles. An odd register index is refused with a one-cycle `err_odd` pulse, and no access is made.

Top module: `dword_pair_seq`

## Requirements
- R1: The access address is base + sign-extended 16-bit offset with bits [1:0] cleared. Every address driven on `mem_addr` has bits [1:0] equal to zero.
- R2: A load with an even index `rt` first reads the aligned address and writes that word to register `rt+1`. It then reads address+4 and writes that word to register `rt`. Each register write happens in the cycle its read handshake completes.
- R3: A store with an even index `rt` first writes the value of `rt` to address+4 (`mem_we`=1). It then writes the value of `rt+1` to the aligned address. Both values are sampled when the request is accepted.
- R4: A request with `req_reg[0]`=1 makes `err_odd` high for exactly the one cycle after acceptance. It makes no memory access and no register write, and `busy` stays low.
- R5: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` keep their values in the next cycle.
- R6: `busy` is high from the cycle after an even request is accepted through the `done` cycle. While `busy` is high, `req_ready` is low and any request presented is ignored. With L stall cycles per access, `busy` lasts 2L+3 cycles.
- R7: `done` is high for one cycle, the cycle after the second access handshake, and `mem_req` is low in that cycle.
- R8: After reset the block is idle: `req_ready`=1, and `busy`, `mem_req`, `rf_wr_en`, `done` and `err_odd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_base | input | 32 | Base value |
| req_offset | input | 16 | Signed displacement |
| req_reg | input | 5 | Register index rt (must be even) |
| req_store | input | 1 | 1 = store, 0 = load |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_odd | output | 1 | One-cycle pulse: odd register index refused |
| rf_rd_even_addr | output | 5 | Read port A index (rt) |
| rf_rd_even_data | input | 32 | Read port A data |
| rf_rd_odd_addr | output | 5 | Read port B index (rt+1) |
| rf_rd_odd_data | input | 32 | Read port B data |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_addr | output | 5 | Register write index |
| rf_wr_data | output | 32 | Register write data |
| mem_req | output | 1 | Memory access valid |
| mem_ready | input | 1 | Memory access accepted/completed |
| mem_we | output | 1 | 1 = word write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |

## Verification
A wrong sequencer state shows at the memory port within one cycle. An access can be dropped, repeated or issued in the wrong order, and an address can fail to follow its stall. Each of these appears in the log of memory handshakes. A wrong choice of address lane or register lane appears as swapped words in `rt` and `rt+1`, or in memory, as soon as the operation ends. A wrong busy or done timing shows as a `busy` length other than 2L+3 cycles. An accepted request while busy shows as extra handshakes in the log.

// File: rtl/dwseq_pkg.sv
package dwseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC0 = 2'd1,
    ST_ACC1 = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dwseq_addr.sv
module dwseq_addr #(
  parameter int AW    = 32,
  parameter int OFFW  = 16,
  parameter int ALIGN = 2
) (
  input  logic [AW-1:0]   base,
  input  logic [OFFW-1:0] offset,
  output logic [AW-1:0]   ea
);
  logic [AW-1:0] ext;
  logic [AW-1:0] sum;

  always_comb begin
    ext = {{(AW-OFFW){offset[OFFW-1]}}, offset};
    sum = base + ext;
    ea  = sum;
    ea[ALIGN-1:0] = '0;
  end
endmodule

// File: rtl/dwseq_fsm.sv
module dwseq_fsm
  import dwseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mem_ready,
  output seq_state_e state
);
  seq_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start)     nxt = ST_ACC0;
      ST_ACC0: if (mem_ready) nxt = ST_ACC1;
      ST_ACC1: if (mem_ready) nxt = ST_DONE;
      ST_DONE:                nxt = ST_IDLE;
      default:                nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/dwseq_steer.sv
module dwseq_steer
  import dwseq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  seq_state_e     state,
  input  logic           store,
  input  logic [AW-1:0]  ea,
  input  logic [RW-1:0]  rt,
  input  logic [DW-1:0]  even_val,
  input  logic [DW-1:0]  odd_val,
  input  logic           mem_ready,
  input  logic [DW-1:0]  mem_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           rf_wr_en,
  output logic [RW-1:0]  rf_wr_addr,
  output logic [DW-1:0]  rf_wr_data
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic          first;
  logic          upper;
  logic [RW-1:0] rt_odd;

  always_comb begin
    first  = (state == ST_ACC0);
    mem_req = (state == ST_ACC0) || (state == ST_ACC1);
    mem_we  = mem_req && store;
    // loads walk up from the aligned word; stores walk down from the upper word
    upper     = store ? first : !first;
    mem_addr  = upper ? ea + STEP : ea;
    mem_wdata = upper ? even_val : odd_val;
    rt_odd    = rt | RW'(1);
    rf_wr_en   = mem_req && mem_ready && !store;
    rf_wr_addr = upper ? rt : rt_odd;
    rf_wr_data = mem_rdata;
  end
endmodule

// File: rtl/dword_pair_seq.sv
module dword_pair_seq
  import dwseq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int OFFW = 16,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_base,
  input  logic [OFFW-1:0] req_offset,
  input  logic [RW-1:0]   req_reg,
  input  logic            req_store,
  output logic            busy,
  output logic            done,
  output logic            err_odd,
  output logic [RW-1:0]   rf_rd_even_addr,
  input  logic [DW-1:0]   rf_rd_even_data,
  output logic [RW-1:0]   rf_rd_odd_addr,
  input  logic [DW-1:0]   rf_rd_odd_data,
  output logic            rf_wr_en,
  output logic [RW-1:0]   rf_wr_addr,
  output logic [DW-1:0]   rf_wr_data,
  output logic            mem_req,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata
);
  localparam int ALIGN = $clog2(DW / 8);

  seq_state_e    state;
  logic          accept;
  logic          start;
  logic [AW-1:0] ea_now;
  logic [AW-1:0] ea_q;
  logic [RW-1:0] rt_q;
  logic          store_q;
  logic [DW-1:0] even_q;
  logic [DW-1:0] odd_q;
  logic          err_q;

  assign req_ready       = (state == ST_IDLE);
  assign accept          = req_valid && req_ready;
  assign start           = accept && !req_reg[0];
  assign busy            = (state != ST_IDLE);
  assign done            = (state == ST_DONE);
  assign err_odd         = err_q;
  assign rf_rd_even_addr = req_reg;
  assign rf_rd_odd_addr  = req_reg | RW'(1);

  dwseq_addr #(.AW(AW), .OFFW(OFFW), .ALIGN(ALIGN)) u_addr (
    .base   (req_base),
    .offset (req_offset),
    .ea     (ea_now)
  );

  dwseq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_ready (mem_ready),
    .state     (state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q    <= '0;
      rt_q    <= '0;
      store_q <= 1'b0;
      even_q  <= '0;
      odd_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= accept && req_reg[0];
      if (start) begin
        ea_q    <= ea_now;
        rt_q    <= req_reg;
        store_q <= req_store;
        even_q  <= rf_rd_even_data;
        odd_q   <= rf_rd_odd_data;
      end
    end
  end

  dwseq_steer #(.AW(AW), .DW(DW), .RW(RW)) u_steer (
    .state      (state),
    .store      (store_q),
    .ea         (ea_q),
    .rt         (rt_q),
    .even_val   (even_q),
    .odd_val    (odd_q),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .rf_wr_en   (rf_wr_en),
    .rf_wr_addr (rf_wr_addr),
    .rf_wr_data (rf_wr_data)
  );
endmodule

// File: rtl/dwseq_chk.sv
module dwseq_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [RW-1:0] req_reg,
  input logic          busy,
  input logic          done,
  input logic          err_odd,
  input logic          rf_wr_en,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata
);
  p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_write_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (mem_req && mem_ready && !mem_we));

  p_odd_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_reg[0]) |=> (err_odd && !busy && !mem_req));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_no_ready_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !mem_req && !err_odd));
endmodule

bind dword_pair_seq dwseq_chk #(.AW(AW), .DW(DW), .RW(RW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_reg   (req_reg),
  .busy      (busy),
  .done      (done),
  .err_odd   (err_odd),
  .rf_wr_en  (rf_wr_en),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/tb_dword_pair_seq.sv
module tb_dword_pair_seq;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [4:0]  req_reg = '0;
  logic        req_store = 1'b0;
  logic        busy, done, err_odd;
  logic [4:0]  rf_rd_even_addr, rf_rd_odd_addr, rf_wr_addr;
  logic [31:0] rf_rd_even_data, rf_rd_odd_data, rf_wr_data;
  logic        rf_wr_en, mem_req, mem_we;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] regs [0:31];
  logic [31:0] mem  [0:63];
  logic [31:0] log_addr [0:7];
  logic        log_we   [0:7];
  logic [31:0] log_data [0:7];
  int log_n = 0;
  int lat = 0;
  int wcnt = 0;
  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  dword_pair_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_offset(req_offset), .req_reg(req_reg),
    .req_store(req_store), .busy(busy), .done(done), .err_odd(err_odd),
    .rf_rd_even_addr(rf_rd_even_addr), .rf_rd_even_data(rf_rd_even_data),
    .rf_rd_odd_addr(rf_rd_odd_addr), .rf_rd_odd_data(rf_rd_odd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign rf_rd_even_data = regs[rf_rd_even_addr];
  assign rf_rd_odd_data  = regs[rf_rd_odd_addr];
  assign mem_rdata       = mem[mem_addr[7:2]];

  // memory responder: ready decided away from the edge, state kept on the edge
  always @(negedge clk) mem_ready <= mem_req && (wcnt >= lat);

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      wcnt <= 0;
      if (log_n < 8) begin
        log_addr[log_n] <= mem_addr;
        log_we[log_n]   <= mem_we;
        log_data[log_n] <= mem_we ? mem_wdata : mem_rdata;
      end
      log_n <= log_n + 1;
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    end else if (mem_req) begin
      wcnt <= wcnt + 1;
    end
    if (rf_wr_en) regs[rf_wr_addr] <= rf_wr_data;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] b, input logic [15:0] o, input logic [4:0] r,
                       input logic st, input logic spam,
                       output int busy_n, output int done_n, output logic err_first);
    @(negedge clk);
    log_n = 0;
    req_valid = 1'b1; req_base = b; req_offset = o; req_reg = r; req_store = st;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    err_first = err_odd;
    busy_n = 0; done_n = 0;
    while (busy) begin
      busy_n++;
      if (done) done_n++;
      if (spam) begin
        req_valid = !done; req_base = 32'h0; req_offset = 16'h0;
        req_reg = 5'd2; req_store = 1'b1;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R8 req_ready", {31'b0, req_ready}, 32'd1);
    check(busy == 1'b0 && done == 1'b0 && err_odd == 1'b0, "R8 busy/done/err",
          {29'b0, busy, done, err_odd}, 32'd0);
    check(mem_req == 1'b0 && rf_wr_en == 1'b0, "R8 mem_req/rf_wr_en",
          {30'b0, mem_req, rf_wr_en}, 32'd0);
  endtask

  task automatic t_load_basic();
    int bn, dn; logic e;
    lat = 0;
    issue(32'h40, 16'h0008, 5'd4, 1'b0, 1'b0, bn, dn, e);
    check(log_n == 2, "R2 access count", log_n, 2);
    check(log_addr[0] == 32'h48 && !log_we[0], "R2 first read at aligned addr", log_addr[0], 32'h48);
    check(log_addr[1] == 32'h4C && !log_we[1], "R2 second read at addr+4", log_addr[1], 32'h4C);
    check(regs[5] == mem[18], "R2 rt+1 gets lower word", regs[5], mem[18]);
    check(regs[4] == mem[19], "R2 rt gets upper word", regs[4], mem[19]);
    check(bn == 3, "R6 busy length L=0", bn, 3);
    check(dn == 1, "R7 single done pulse", dn, 1);
  endtask

  task automatic t_load_negoff();
    int bn, dn; logic e;
    lat = 2;
    issue(32'h83, 16'hFFFD, 5'd10, 1'b0, 1'b0, bn, dn, e);
    check(log_addr[0] == 32'h80, "R1 negative offset and cleared low bits", log_addr[0], 32'h80);
    check(regs[11] == mem[32] && regs[10] == mem[33], "R2 load with stalls", regs[10], mem[33]);
    check(bn == 7, "R6 busy length L=2", bn, 7);
  endtask

  task automatic t_load_sext();
    int bn, dn; logic e;
    lat = 0;
    issue(32'h0001_0000, 16'h8004, 5'd0, 1'b0, 1'b0, bn, dn, e);
    check(log_addr[0] == 32'h0000_8004, "R1 sign extension of 0x8004", log_addr[0], 32'h0000_8004);
    check(log_addr[1] == 32'h0000_8008, "R1 second address", log_addr[1], 32'h0000_8008);
  endtask

  task automatic t_store();
    int bn, dn; logic e;
    lat = 1;
    regs[6] = 32'h1111_AAAA; regs[7] = 32'h2222_BBBB;
    issue(32'h10, 16'h0022, 5'd6, 1'b1, 1'b0, bn, dn, e);
    check(log_n == 2, "R3 access count", log_n, 2);
    check(log_addr[0] == 32'h34 && log_we[0], "R3 first write at addr+4", log_addr[0], 32'h34);
    check(log_data[0] == 32'h1111_AAAA, "R3 first write from rt", log_data[0], 32'h1111_AAAA);
    check(log_addr[1] == 32'h30 && log_we[1], "R3 second write at addr", log_addr[1], 32'h30);
    check(log_data[1] == 32'h2222_BBBB, "R3 second write from rt+1", log_data[1], 32'h2222_BBBB);
    check(mem[13] == 32'h1111_AAAA && mem[12] == 32'h2222_BBBB, "R3 memory contents", mem[12], 32'h2222_BBBB);
    check(bn == 5, "R6 busy length L=1", bn, 5);
  endtask

  task automatic t_odd();
    int bn, dn; logic e; logic [31:0] keep;
    lat = 0;
    keep = regs[3];
    issue(32'h40, 16'h0000, 5'd3, 1'b0, 1'b0, bn, dn, e);
    check(e == 1'b1, "R4 err_odd pulse", {31'b0, e}, 32'd1);
    check(bn == 0, "R4 busy stays low", bn, 0);
    check(log_n == 0, "R4 no memory access", log_n, 0);
    @(negedge clk);
    check(err_odd == 1'b0, "R4 err_odd one cycle only", {31'b0, err_odd}, 32'd0);
    check(regs[3] == keep, "R4 register untouched", regs[3], keep);
  endtask

  task automatic t_busy_ignore();
    int bn, dn; logic e; logic [31:0] m0;
    lat = 3;
    m0 = mem[0];
    issue(32'h20, 16'h0000, 5'd12, 1'b0, 1'b1, bn, dn, e);
    check(bn == 9, "R6 busy length L=3", bn, 9);
    @(negedge clk); @(negedge clk);
    check(log_n == 2, "R6 request during busy ignored", log_n, 2);
    check(!log_we[0] && !log_we[1], "R5 stalled reads kept direction", {30'b0, log_we[0], log_we[1]}, 32'd0);
    check(log_addr[0] == 32'h20 && log_addr[1] == 32'h24, "R5 stalled addresses held", log_addr[1], 32'h24);
    check(mem[0] == m0, "R6 ignored store left memory", mem[0], m0);
    check(req_ready == 1'b1, "R6 ready again after done", {31'b0, req_ready}, 32'd1);
  endtask

  initial begin
    #(PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 32'hF0F0_0000 + 32'(i);
    for (int i = 0; i < 64; i++) mem[i] = (32'(i) * 32'h0101_0101) ^ 32'hC0DE_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_basic();
    t_load_negoff();
    t_load_sext();
    t_store();
    t_odd();
    t_busy_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule